// File: doc/BRIEF.md
# Boot Mode Sequencer with Byte Loader

This block decides, right after reset is released, how a small processor core gets its first program. It samples a three-bit mode code once, on the first clock edge after reset, and runs one of three sequences. In a byte-loader boot it fetches bytes from an external byte-wide memory and packs every three of them into a 24-bit word. It writes these words into on-chip program memory at consecutive addresses starting from 0. In a host boot it waits until an outside host writes on-chip program address 0. In the no-boot case it lets the core run at once, fetching from external address 0.

The core is held through a single run-enable output. A byte-loader boot sets an internal hold flag, which clears only when the last word of the boot count is committed. The loader's working state starts from fixed values on every boot: page, internal address and external address at zero, and word count at the boot length. The mode code also sets the configuration the chip runs in afterwards. In host configuration the loader drives only bit 0 of the byte address, and outside logic builds the upper address bits.

Top module: `boot_seq_top`

## Requirements
- R1: With mode code 000 (bit 2 to bit 0), the block writes exactly 32 words to program addresses 0, 1, 2 … 31 in that order. `hostMode` is 0 and `coreFromExt` is 0 after sampling.
- R2: Each written word is built from three consecutive returned bytes, first byte in bits 23:16, second in 15:8, third in 7:0. In full-memory configuration the byte address of the n-th read (counting from 0) is n.
- R3: `coreRun` is 0 during reset and during every program-memory write of a byte-loader boot. It is 1 in the cycle after the last of the 32 writes.
- R4: With mode code 100, the load of R1 and R2 takes place with `hostMode` at 1. On every read in host configuration, byte address bits above bit 0 are 0, and bit 0 equals bit 0 of the read index.
- R5: With mode code 010, `coreRun` is 1 by the second cycle after reset release and `coreFromExt` is 1. No byte read and no program write occur.
- R6: With mode code 101, `hostMode` is 1 and no byte read occurs. Host writes to nonzero addresses leave `coreRun` at 0. The cycle after a host write to address 0, `coreRun` is 1.
- R7: Mode codes 001, 011, 110 and 111 behave as the no-boot case of R5.
- R8: A change of the mode pins after the sampling edge has no effect on a boot in progress or on its outputs.
- R9: At most one byte read is outstanding: a read request is never asserted in two consecutive cycles, and a new request waits for the returned byte.
- R10: Once `coreRun` is 1, no further byte read or program write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modePins | input | 3 | Boot mode code, sampled at the first edge after reset release |
| bmReq | output | 1 | Byte-memory read request, one cycle per byte |
| bmAddr | output | 16 | Byte-memory address (page and offset, or only bit 0 in host configuration) |
| bmData | input | 8 | Returned byte |
| bmValid | input | 1 | Returned byte is valid, one cycle after the request |
| pmWe | output | 1 | Program-memory write strobe |
| pmAddr | output | 11 | Program-memory write address |
| pmData | output | 24 | Program-memory write word |
| hostWe | input | 1 | Observed host write to program memory |
| hostAddr | input | 11 | Address of the observed host write |
| coreRun | output | 1 | Core may execute |
| coreFromExt | output | 1 | Core starts from external address 0 (no-boot case) |
| hostMode | output | 1 | Chip runs in host configuration |

## Verification
The case that is hardest to reach is the release edge of a byte-loader boot. Here the hold flag must clear at the same edge that the 32nd word is committed, and not one word early or late. A scoreboard of the 32 expected words therefore checks `coreRun` low on every write and high in the cycle after the queue empties. A second case is mode pins that change mid-boot. One run switches the pins to the no-boot code partway through a load, and the bench confirms that all 32 words still arrive and that the core stays held until the end.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_BYTE = 2'd1,
    BK_HOST = 2'd2
  } bootKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic initRegs;
    logic setHold;
    logic issueRead;
    logic takeByte;
    logic commitWord;
  } dpStrobe_t;

  function automatic bootKind_e decodeKind(input logic [2:0] code);
    case (code)
      3'b000, 3'b100: decodeKind = BK_BYTE;
      3'b101:         decodeKind = BK_HOST;
      default:        decodeKind = BK_NONE;
    endcase
  endfunction

  function automatic logic decodeHostCfg(input logic [2:0] code);
    decodeHostCfg = (code == 3'b100) || (code == 3'b101);
  endfunction

endpackage

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [2:0] modePins,
  input  logic      bmValid,
  input  logic      lastByte,
  input  logic      lastWord,
  input  logic      hostWe,
  input  logic      hostAddrZero,
  output dpStrobe_t strb,
  output logic      bmReq,
  output logic      hostCfg,
  output logic      fromExt,
  output logic      inRun
);

  typedef enum logic [2:0] {
    ST_SAMPLE = 3'd0,
    ST_FETCH  = 3'd1,
    ST_WAIT   = 3'd2,
    ST_WRITE  = 3'd3,
    ST_HOST   = 3'd4,
    ST_RUN    = 3'd5
  } state_e;

  state_e state, nxtState;
  bootKind_e pinKind;

  assign pinKind = decodeKind(modePins);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_SAMPLE;
      hostCfg <= 1'b0;
      fromExt <= 1'b0;
    end else begin
      state <= nxtState;
      if (state == ST_SAMPLE) begin
        hostCfg <= decodeHostCfg(modePins);
        fromExt <= (pinKind == BK_NONE);
      end
    end
  end

  always_comb begin
    nxtState = state;
    strb     = '0;
    case (state)
      ST_SAMPLE: begin
        strb.initRegs = 1'b1;
        case (pinKind)
          BK_BYTE: begin
            strb.setHold = 1'b1;
            nxtState     = ST_FETCH;
          end
          BK_HOST: nxtState = ST_HOST;
          default: nxtState = ST_RUN;
        endcase
      end
      ST_FETCH: begin
        strb.issueRead = 1'b1;
        nxtState       = ST_WAIT;
      end
      ST_WAIT: begin
        if (bmValid) begin
          strb.takeByte = 1'b1;
          nxtState      = lastByte ? ST_WRITE : ST_FETCH;
        end
      end
      ST_WRITE: begin
        strb.commitWord = 1'b1;
        nxtState        = lastWord ? ST_RUN : ST_FETCH;
      end
      ST_HOST: begin
        if (hostWe && hostAddrZero) nxtState = ST_RUN;
      end
      default: nxtState = ST_RUN;
    endcase
  end

  assign bmReq = strb.issueRead;
  assign inRun = (state == ST_RUN);

  // R8: configuration taken at the sampling edge never moves afterwards
  p_mode_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_SAMPLE) |=> ($stable(hostCfg) && $stable(fromExt)));

  // R9: a request is followed by a cycle without a request
  p_one_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    bmReq |=> !bmReq);

  // R6: host wait is left only through a write to address 0
  p_host_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOST && !(hostWe && hostAddrZero)) |=> (state == ST_HOST));

endmodule

// File: rtl/boot_seq_dpath.sv
module boot_seq_dpath
  import boot_seq_pkg::*;
#(
  parameter int BytesPerWord = 3,
  parameter int PmAddrW      = 11,
  parameter int ExtAddrW     = 14,
  parameter int PageW        = 2,
  parameter int BootWords    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strb,
  input  logic [7:0]                  bmData,
  output logic [PageW+ExtAddrW-1:0]   byteAddr,
  output logic [PmAddrW-1:0]          pmAddr,
  output logic [8*BytesPerWord-1:0]   pmData,
  output logic                        lastByte,
  output logic                        lastWord,
  output logic                        holdBit
);

  localparam int WordW = 8 * BytesPerWord;
  localparam int CntW  = $clog2(BootWords + 1);
  localparam int IdxW  = (BytesPerWord > 1) ? $clog2(BytesPerWord) : 1;
  localparam logic [IdxW-1:0] LastIdx   = IdxW'(BytesPerWord - 1);
  localparam logic [CntW-1:0] CountInit = CntW'(BootWords);

  logic [PageW-1:0]    pageReg;
  logic [ExtAddrW-1:0] extAddr;
  logic [PmAddrW-1:0]  intAddr;
  logic [CntW-1:0]     wordsLeft;
  logic [IdxW-1:0]     byteIdx;
  logic [WordW-1:0]    assembly;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg   <= '0;
      extAddr   <= '0;
      intAddr   <= '0;
      wordsLeft <= CountInit;
      byteIdx   <= '0;
      assembly  <= '0;
      holdBit   <= 1'b0;
    end else begin
      if (strb.initRegs) begin
        pageReg   <= '0;
        extAddr   <= '0;
        intAddr   <= '0;
        wordsLeft <= CountInit;
        byteIdx   <= '0;
      end
      if (strb.setHold) holdBit <= 1'b1;
      if (strb.takeByte) begin
        if (BytesPerWord > 1) assembly <= {assembly[WordW-9:0], bmData};
        else                  assembly <= WordW'(bmData);
        extAddr <= extAddr + 1'b1;
        byteIdx <= (byteIdx == LastIdx) ? '0 : byteIdx + 1'b1;
      end
      if (strb.commitWord) begin
        intAddr   <= intAddr + 1'b1;
        wordsLeft <= wordsLeft - 1'b1;
        if (wordsLeft == CntW'(1)) holdBit <= 1'b0;
      end
    end
  end

  assign byteAddr = {pageReg, extAddr};
  assign pmAddr   = intAddr;
  assign pmData   = assembly;
  assign lastByte = (byteIdx == LastIdx);
  assign lastWord = (wordsLeft == CntW'(1));

  // R3: the hold flag drops only on the commit of the final word
  p_hold_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdBit) |-> $past(strb.commitWord && wordsLeft == CntW'(1)));

  // R1: each committed word advances the program address by one
  p_int_addr_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitWord && !strb.initRegs) |=> (intAddr == $past(intAddr) + 1'b1));

  // R2: byte position inside a word stays in range
  p_byte_idx_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    byteIdx <= LastIdx);

endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int BytesPerWord = 3,
  parameter int PmAddrW      = 11,
  parameter int ExtAddrW     = 14,
  parameter int PageW        = 2,
  parameter int BootWords    = 32,
  localparam int ByteAddrW   = PageW + ExtAddrW,
  localparam int WordW       = 8 * BytesPerWord
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           modePins,
  output logic                 bmReq,
  output logic [ByteAddrW-1:0] bmAddr,
  input  logic [7:0]           bmData,
  input  logic                 bmValid,
  output logic                 pmWe,
  output logic [PmAddrW-1:0]   pmAddr,
  output logic [WordW-1:0]     pmData,
  input  logic                 hostWe,
  input  logic [PmAddrW-1:0]   hostAddr,
  output logic                 coreRun,
  output logic                 coreFromExt,
  output logic                 hostMode
);

  dpStrobe_t            strb;
  logic                 lastByte, lastWord, holdBit, inRun;
  logic [ByteAddrW-1:0] byteAddr;

  boot_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .modePins     (modePins),
    .bmValid      (bmValid),
    .lastByte     (lastByte),
    .lastWord     (lastWord),
    .hostWe       (hostWe),
    .hostAddrZero (hostAddr == '0),
    .strb         (strb),
    .bmReq        (bmReq),
    .hostCfg      (hostMode),
    .fromExt      (coreFromExt),
    .inRun        (inRun)
  );

  boot_seq_dpath #(
    .BytesPerWord (BytesPerWord),
    .PmAddrW      (PmAddrW),
    .ExtAddrW     (ExtAddrW),
    .PageW        (PageW),
    .BootWords    (BootWords)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .bmData   (bmData),
    .byteAddr (byteAddr),
    .pmAddr   (pmAddr),
    .pmData   (pmData),
    .lastByte (lastByte),
    .lastWord (lastWord),
    .holdBit  (holdBit)
  );

  // host configuration: only bit 0 leaves the block
  assign bmAddr  = hostMode ? {{(ByteAddrW-1){1'b0}}, byteAddr[0]} : byteAddr;
  assign pmWe    = strb.commitWord;
  assign coreRun = inRun && !holdBit;

  // R10: a running core sees no loader traffic
  p_quiet_after_run_r10: assert property (@(posedge clk) disable iff (!rstN)
    coreRun |-> (!pmWe && !bmReq));

  // R4: upper byte-address bits stay low in host configuration
  p_host_a0_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    (bmReq && hostMode) |-> (bmAddr[ByteAddrW-1:1] == '0));

  // R3: no write lands while the core is enabled
  p_stall_during_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    pmWe |-> !coreRun);

endmodule

// File: tb/sim_boot_seq_top.sv
module sim_boot_seq_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  modePins = 3'b000;
  logic        bmReq;
  logic [15:0] bmAddr;
  logic [7:0]  bmData = '0;
  logic        bmValid = 1'b0;
  logic        pmWe;
  logic [10:0] pmAddr;
  logic [23:0] pmData;
  logic        hostWe = 1'b0;
  logic [10:0] hostAddr = '0;
  logic        coreRun, coreFromExt, hostMode;

  always #5 clk = ~clk;

  boot_seq_top u0 (
    .clk(clk), .rstN(rstN), .modePins(modePins),
    .bmReq(bmReq), .bmAddr(bmAddr), .bmData(bmData), .bmValid(bmValid),
    .pmWe(pmWe), .pmAddr(pmAddr), .pmData(pmData),
    .hostWe(hostWe), .hostAddr(hostAddr),
    .coreRun(coreRun), .coreFromExt(coreFromExt), .hostMode(hostMode)
  );

  int checks = 0;
  int fails  = 0;
  int seed   = 0;
  int memIdx = 0;
  int reqIdx = 0;
  bit expectReads = 0;
  bit expHostAddr = 0;
  bit prevReq = 0;
  string curTag = "R1";
  int          expAddrQ[$];
  logic [23:0] expDataQ[$];

  function automatic logic [7:0] byteFn(input int s, input int i);
    byteFn = 8'((i * 29 + s * 7 + (i >> 3)) ^ s);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // byte memory: one cycle latency, address built externally from a counter
  always @(posedge clk) begin
    if (!rstN) begin
      memIdx  <= 0;
      bmValid <= 1'b0;
    end else begin
      bmValid <= bmReq;
      if (bmReq) begin
        bmData <= byteFn(seed, memIdx);
        memIdx <= memIdx + 1;
      end
    end
  end

  // monitor: pops the scoreboard and checks read addresses
  always @(negedge clk) begin
    if (!rstN) begin
      reqIdx  = 0;
      prevReq = 0;
    end else begin
      if (pmWe) begin
        if (expAddrQ.size() == 0) begin
          chk(0, "R10", "unexpected program write", pmAddr, 0);
        end else begin
          int ea;
          logic [23:0] ed;
          ea = expAddrQ.pop_front();
          ed = expDataQ.pop_front();
          chk(pmAddr == 11'(ea), "R1", "write address", pmAddr, ea);
          chk(pmData == ed, "R2", "packed word", pmData, ed);
          chk(coreRun == 1'b0, "R3", "core held during write", coreRun, 0);
        end
      end
      if (bmReq) begin
        if (!expectReads) begin
          chk(0, curTag, "unexpected byte read", bmAddr, 0);
        end else if (expHostAddr) begin
          chk(bmAddr == 16'(reqIdx & 1), "R4", "host A0 address", bmAddr, reqIdx & 1);
        end else begin
          chk(bmAddr == 16'(reqIdx), "R2", "byte address", bmAddr, reqIdx);
        end
        chk(!prevReq, "R9", "back-to-back request", prevReq, 0);
        reqIdx++;
      end
      prevReq = bmReq;
    end
  end

  task automatic startBoot(input logic [2:0] mode);
    rstN = 1'b0;
    modePins = mode;
    repeat (3) @(negedge clk);
    chk(coreRun == 1'b0 && pmWe == 1'b0 && bmReq == 1'b0, "R3",
        "reset state", {coreRun, pmWe, bmReq}, 0);
    rstN = 1'b1;
  endtask

  task automatic runByteBoot(input logic [2:0] mode, input int s, input bit midChange);
    int cyc;
    seed = s;
    expectReads = 1;
    expHostAddr = (mode == 3'b100);
    curTag = expHostAddr ? "R4" : "R1";
    expAddrQ.delete();
    expDataQ.delete();
    for (int i = 0; i < 32; i++) begin
      expAddrQ.push_back(i);
      expDataQ.push_back({byteFn(s, 3*i), byteFn(s, 3*i+1), byteFn(s, 3*i+2)});
    end
    @(negedge clk);
    startBoot(mode);
    cyc = 0;
    while (expAddrQ.size() != 0 && cyc < 2000) begin
      @(posedge clk);
      cyc++;
      if (midChange && cyc == 40) modePins = 3'b010;   // R8 stimulus
    end
    @(negedge clk);
    chk(coreRun == 1'b1, midChange ? "R8" : "R3", "release after last word", coreRun, 1);
    chk(reqIdx == 96, "R2", "byte read count", reqIdx, 96);
    chk(hostMode == expHostAddr, expHostAddr ? "R4" : "R1", "host configuration", hostMode, expHostAddr);
    chk(coreFromExt == 1'b0, "R1", "internal start", coreFromExt, 0);
    expectReads = 0;
    curTag = "R10";
    begin
      bit quiet = 1;
      repeat (10) begin
        @(negedge clk);
        if (pmWe || bmReq || !coreRun) quiet = 0;
      end
      chk(quiet, "R10", "no traffic after run", quiet, 1);
    end
  endtask

  task automatic runNoBoot(input logic [2:0] mode, input string tag);
    expectReads = 0;
    curTag = tag;
    expAddrQ.delete();
    expDataQ.delete();
    @(negedge clk);
    startBoot(mode);
    repeat (2) @(negedge clk);
    chk(coreRun == 1'b1, tag, "no-boot run", coreRun, 1);
    chk(coreFromExt == 1'b1, tag, "external start", coreFromExt, 1);
    chk(hostMode == 1'b0, tag, "full configuration", hostMode, 0);
    modePins = 3'b101;     // R8: late change ignored
    repeat (4) @(negedge clk);
    chk(coreRun == 1'b1 && coreFromExt == 1'b1, "R8", "late pin change",
        {coreRun, coreFromExt}, 3);
  endtask

  task automatic runHostBoot();
    expectReads = 0;
    curTag = "R6";
    expAddrQ.delete();
    expDataQ.delete();
    @(negedge clk);
    startBoot(3'b101);
    repeat (3) @(negedge clk);
    chk(coreRun == 1'b0, "R6", "held before host write", coreRun, 0);
    chk(hostMode == 1'b1, "R6", "host configuration", hostMode, 1);
    hostWe = 1'b1;
    hostAddr = 11'd7;
    @(negedge clk);
    hostWe = 1'b0;
    hostAddr = 11'd1;
    hostWe = 1'b1;
    @(negedge clk);
    hostWe = 1'b0;
    @(negedge clk);
    chk(coreRun == 1'b0, "R6", "nonzero host writes ignored", coreRun, 0);
    hostWe = 1'b1;
    hostAddr = 11'd0;
    @(negedge clk);
    hostWe = 1'b0;
    chk(coreRun == 1'b1, "R6", "release on address 0", coreRun, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    runByteBoot(3'b000, 3, 0);     // R1 R2 R3
    runByteBoot(3'b100, 91, 0);    // R4
    runByteBoot(3'b000, 200, 1);   // R8 mid-boot change
    runNoBoot(3'b010, "R5");
    runNoBoot(3'b001, "R7");
    runNoBoot(3'b011, "R7");
    runNoBoot(3'b110, "R7");
    runNoBoot(3'b111, "R7");
    runHostBoot();                 // R6
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule